// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block carries out the three register-to-register operate instructions of a small 16-bit machine: addition, bitwise AND and bitwise complement, on two's-complement words. It splits the 16-bit instruction word into its fields and reports the destination and source register numbers to a register file that lives outside the block. The second operand of ADD and AND comes either from a register or from a sign-extended 5-bit constant held in the instruction. The result and a write strobe go back out to that register file in the same cycle.

The block also holds the machine's three-bit condition register, which is one-hot over negative, zero and positive. This register is updated on the clock edge after any register write. That includes the writes made here and the writes that a load or address-forming instruction reports through a separate write-back strobe. Any other instruction leaves the flags alone.

Top module: `opu_top`

## Requirements
- R1: The destination index is instruction bits [11:9], the first source index is bits [8:6] and the second source index is bits [2:0]. All three are shown on their outputs for any instruction word.
- R2: ADD (bits [15:12] = 4'b0001) with bit 5 clear returns src_a + src_b, taken modulo 2^16.
- R3: ADD with bit 5 set returns src_a plus bits [4:0] sign-extended to 16 bits, taken modulo 2^16.
- R4: AND (bits [15:12] = 4'b0101) returns src_a & src_b when bit 5 is clear, and src_a & sign-extended bits [4:0] when bit 5 is set.
- R5: NOT (bits [15:12] = 4'b1001) returns ~src_a. Source and destination may name the same register.
- R6: reg_we is high in the same cycle exactly when instr_valid is high and the opcode is ADD, AND or NOT. In every other case reg_we is low and result is zero.
- R7: Exactly one of flag_n, flag_z, flag_p is high at all times. After reset only flag_z is high.
- R8: On the clock edge after a cycle with reg_we high, the flags take the class of result: N if bit 15 is set, Z if the value is zero, P otherwise.
- R9: On the clock edge after a cycle with ld_wb_valid high and reg_we low, the flags take the class of ld_wb_data.
- R10: If reg_we and ld_wb_valid are both low, the flags keep their value. This covers stores, branches and any non-operate opcode.
- R11: If reg_we and ld_wb_valid are both high, the flags follow result and ignore ld_wb_data.
- R12: Arithmetic overflow wraps without notice. For example 0x7FFF + 1 gives 0x8000, and the flags then read N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the condition register |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | Instruction word is live this cycle |
| src_a | input | 16 | Value of the first source register |
| src_b | input | 16 | Value of the second source register |
| ld_wb_valid | input | 1 | A load or address-forming instruction writes a register this cycle |
| ld_wb_data | input | 16 | Value that write-back stores |
| result | output | 16 | Operate result |
| dst_idx | output | 3 | Destination register index |
| srca_idx | output | 3 | First source register index |
| srcb_idx | output | 3 | Second source register index |
| reg_we | output | 1 | Register write strobe for result |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
The operate path is driven with register and immediate forms using positive, negative and extreme immediates. This separates a correct sign extension from zero extension, and the register operand from the immediate. Operand pairs are chosen so that each of the three flag classes results, and so that 0x7FFF + 1 shows that the sum wraps without saturating. Non-operate opcodes, a dropped instr_valid, load-only strobes and a load strobe that coincides with an operate show which source the flag register follows and when it holds its value.

// File: rtl/opu_pkg.sv
package opu_pkg;
  typedef enum logic [3:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opc_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;

  localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int IMM_W  = 5
) (
  input  logic [15:0]       instr,
  input  logic              instr_valid,
  output logic [IDX_W-1:0]  dst,
  output logic [IDX_W-1:0]  sa,
  output logic [IDX_W-1:0]  sb,
  output logic              use_imm,
  output logic [DATA_W-1:0] imm_ext,
  output logic              do_add,
  output logic              do_and,
  output logic              do_not
);
  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  logic [3:0] opc;
  assign opc     = instr[15:12];
  assign dst     = instr[11:9];
  assign sa      = instr[8:6];
  assign sb      = instr[2:0];
  assign use_imm = instr[5];
  assign imm_ext = sext_imm(instr[IMM_W-1:0]);

  assign do_add = instr_valid && (opc == OPC_ADD);
  assign do_and = instr_valid && (opc == OPC_AND);
  assign do_not = instr_valid && (opc == OPC_NOT);
endmodule

// File: rtl/opu_exec.sv
module opu_exec #(
  parameter int DATA_W = 16
) (
  input  logic              do_add,
  input  logic              do_and,
  input  logic              do_not,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm_ext,
  output logic [DATA_W-1:0] res,
  output logic              wr
);
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [DATA_W:0] full;
    full = {1'b0, x} + {1'b0, y};
    return full[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] opnd2;
  assign opnd2 = use_imm ? imm_ext : b;

  always_comb begin
    res = '0;
    if (do_add)      res = add_wrap(a, opnd2);
    else if (do_and) res = a & opnd2;
    else if (do_not) res = ~a;
  end

  assign wr = do_add | do_and | do_not;
endmodule

// File: rtl/opu_ccreg.sv
module opu_ccreg
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_we,
  input  logic [DATA_W-1:0] op_val,
  input  logic              ld_v,
  input  logic [DATA_W-1:0] ld_val,
  output cc_t               cc
);
  function automatic cc_t classify(input logic [DATA_W-1:0] v);
    cc_t c;
    c.neg  = v[DATA_W-1];
    c.zero = (v == '0);
    c.pos  = !v[DATA_W-1] && (v != '0);
    return c;
  endfunction

  logic              upd_evt;
  logic [DATA_W-1:0] upd_val;
  assign upd_evt = op_we | ld_v;
  assign upd_val = op_we ? op_val : ld_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cc <= CC_RESET;
    else if (upd_evt) cc <= classify(upd_val);
  end

  // R7
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cc));

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_we && !ld_v) |=> $stable(cc));

  // R8
  cc_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> (cc.neg == $past(op_val[DATA_W-1])) && (cc.zero == ($past(op_val) == '0)));

  // R9
  cc_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_v && !op_we) |=> (cc.neg == $past(ld_val[DATA_W-1])) && (cc.zero == ($past(ld_val) == '0)));
endmodule

// File: rtl/opu_top.sv
module opu_top
  import opu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  input  logic              instr_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              ld_wb_valid,
  input  logic [DATA_W-1:0] ld_wb_data,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [IDX_W-1:0]  srca_idx,
  output logic [IDX_W-1:0]  srcb_idx,
  output logic              reg_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  logic              use_imm, do_add, do_and, do_not;
  logic [DATA_W-1:0] imm_ext;
  cc_t               cc;

  opu_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
    .instr(instr), .instr_valid(instr_valid),
    .dst(dst_idx), .sa(srca_idx), .sb(srcb_idx),
    .use_imm(use_imm), .imm_ext(imm_ext),
    .do_add(do_add), .do_and(do_and), .do_not(do_not)
  );

  opu_exec #(.DATA_W(DATA_W)) u_exe (
    .do_add(do_add), .do_and(do_and), .do_not(do_not), .use_imm(use_imm),
    .a(src_a), .b(src_b), .imm_ext(imm_ext),
    .res(result), .wr(reg_we)
  );

  opu_ccreg #(.DATA_W(DATA_W)) u_cc (
    .clk(clk), .rst_n(rst_n),
    .op_we(reg_we), .op_val(result),
    .ld_v(ld_wb_valid), .ld_val(ld_wb_data),
    .cc(cc)
  );

  assign flag_n = cc.neg;
  assign flag_z = cc.zero;
  assign flag_p = cc.pos;

  // R6
  we_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (instr_valid && (instr[15:12] inside {OPC_ADD, OPC_AND, OPC_NOT})));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (result == '0));
endmodule

// File: tb/opu_top_test.sv
module opu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        instr_valid = 1'b0;
  logic [15:0] src_a = '0, src_b = '0;
  logic        ld_wb_valid = 1'b0;
  logic [15:0] ld_wb_data = '0;
  logic [15:0] result;
  logic [2:0]  dst_idx, srca_idx, srcb_idx;
  logic        reg_we, flag_n, flag_z, flag_p;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [2:0] cc;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  logic [2:0] model_cc = 3'b010;

  always #5 clk = ~clk;

  opu_top uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
    .src_a(src_a), .src_b(src_b), .ld_wb_valid(ld_wb_valid), .ld_wb_data(ld_wb_data),
    .result(result), .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .reg_we(reg_we), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] sign_class(input logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 16'd0)     return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [15:0] mk_reg(input logic [3:0] op, input logic [2:0] d,
                                         input logic [2:0] s1, input logic [2:0] s2);
    return {op, d, s1, 3'b000, s2};
  endfunction

  function automatic logic [15:0] mk_imm(input logic [3:0] op, input logic [2:0] d,
                                         input logic [2:0] s1, input logic [4:0] k);
    return {op, d, s1, 1'b1, k};
  endfunction

  // driver: applies one cycle of stimulus, checks same-cycle outputs, queues flag expectation
  task automatic issue(input string tag, input logic [15:0] iw, input logic v,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic lv, input logic [15:0] ld);
    logic [15:0] exp_res;
    logic        exp_we;
    logic [15:0] opnd;
    @(negedge clk);
    instr = iw; instr_valid = v; src_a = a; src_b = b;
    ld_wb_valid = lv; ld_wb_data = ld;
    #2;
    opnd    = iw[5] ? 16'($signed(iw[4:0])) : b;
    exp_we  = 1'b0;
    exp_res = 16'h0000;
    if (v) begin
      case (iw[15:12])
        4'b0001: begin exp_we = 1'b1; exp_res = 16'(a + opnd); end
        4'b0101: begin exp_we = 1'b1; exp_res = a & opnd; end
        4'b1001: begin exp_we = 1'b1; exp_res = a ^ 16'hFFFF; end
        default: ;
      endcase
    end
    chk({tag, " result"}, result, exp_res);
    chk("R6 reg_we", {15'd0, reg_we}, {15'd0, exp_we});
    chk("R1 indices", {7'd0, dst_idx, srca_idx, srcb_idx}, {7'd0, iw[11:9], iw[8:6], iw[2:0]});
    if (exp_we)  model_cc = sign_class(exp_res);
    else if (lv) model_cc = sign_class(ld);
    exp_q.push_back('{cc: model_cc, tag: tag});
  endtask

  // monitor: compares flags one edge after each driven cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " flags"}, {13'd0, flag_n, flag_z, flag_p}, {13'd0, e.cc});
      tests++;
      if ($countones({flag_n, flag_z, flag_p}) != 1) begin
        fails++;
        $display("FAIL R7 onehot: actual %b expected one-hot", {flag_n, flag_z, flag_p});
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset flags", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);

    issue("R2 add reg pos",   mk_reg(4'h1, 3'd1, 3'd2, 3'd3), 1, 16'd5, 16'd7, 0, 0);
    issue("R3 add imm neg",   mk_imm(4'h1, 3'd4, 3'd4, 5'b11101), 1, 16'd5, 16'hAAAA, 0, 0);
    issue("R3 add imm min",   mk_imm(4'h1, 3'd0, 3'd7, 5'b10000), 1, 16'd3, 16'd0, 0, 0);
    issue("R3 add imm max",   mk_imm(4'h1, 3'd6, 3'd5, 5'b01111), 1, 16'hFFF1, 16'd0, 0, 0);
    issue("R4 and reg",       mk_reg(4'h5, 3'd2, 3'd1, 3'd6), 1, 16'hF0F0, 16'h3C3C, 0, 0);
    issue("R4 and imm zero",  mk_imm(4'h5, 3'd3, 3'd3, 5'b00000), 1, 16'h1234, 16'hFFFF, 0, 0);
    issue("R4 and imm sext",  mk_imm(4'h5, 3'd5, 3'd2, 5'b11110), 1, 16'h8001, 16'd0, 0, 0);
    issue("R5 not same reg",  {4'h9, 3'd2, 3'd2, 6'h3F}, 1, 16'h00FF, 16'd0, 0, 0);
    issue("R5 not to zero",   {4'h9, 3'd7, 3'd1, 6'h3F}, 1, 16'hFFFF, 16'd0, 0, 0);
    issue("R12 wrap",         mk_imm(4'h1, 3'd1, 3'd1, 5'b00001), 1, 16'h7FFF, 16'd0, 0, 0);
    issue("R12 wrap to zero", mk_reg(4'h1, 3'd1, 3'd2, 3'd3), 1, 16'hFFFF, 16'd1, 0, 0);
    issue("R9 load neg",      16'h2A05, 1, 16'd1, 16'd1, 1, 16'h9000);
    issue("R10 store hold",   16'h3A05, 1, 16'd0, 16'd0, 0, 16'd0);
    issue("R10 branch hold",  16'h0E03, 1, 16'd9, 16'd9, 0, 16'd0);
    issue("R6 invalid hold",  mk_reg(4'h1, 3'd1, 3'd2, 3'd3), 0, 16'd0, 16'd0, 0, 0);
    issue("R9 load zero",     16'h6000, 1, 16'd0, 16'd0, 1, 16'h0000);
    issue("R9 lea pos",       16'hE20A, 1, 16'd0, 16'd0, 1, 16'h3010);
    issue("R11 op over load", mk_reg(4'h5, 3'd0, 3'd1, 3'd2), 1, 16'h8000, 16'h8000, 1, 16'h0001);
    issue("R11 op zero",      mk_reg(4'h5, 3'd0, 3'd1, 3'd2), 1, 16'h00F0, 16'h0F00, 1, 16'h8000);
    issue("R8 add neg",       mk_reg(4'h1, 3'd3, 3'd4, 3'd5), 1, 16'hFFF0, 16'd4, 0, 0);

    @(negedge clk);
    instr_valid = 1'b0; ld_wb_valid = 1'b0; instr = '0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule